// File: doc/BRIEF.md
# Video Zebra Exposure Overlay

This block sits in a streaming YUV pixel path and paints a moving diagonal pattern over parts of the picture that are too bright or too dark. Each incoming pixel arrives with its luma, two chroma components, a valid flag and its column/row position. A separate strobe marks the start of each frame. The block compares the luma against two independently configured thresholds, one for highlights and one for shadows. Where a pixel falls inside a marked region and the channel's stripe or dot pattern is lit at that position, the block blends the pixel toward that channel's tint.

Each channel is configured by two 32-bit words. A packed style word carries the visibility, motion speed, stripe angle, pattern style, opacity and thresholds. A packed tint word carries the target colour. A global enable word switches the whole overlay on and off. Register decoding, frame fetch and display timing sit outside the block. The configuration is taken as plain levels that are held stable while pixels stream.

Every pattern has an 8-pixel period. Each channel keeps its own pattern offset, which steps at each frame start so that the stripes crawl across the picture.

Top module: `zebra_overlay`

## Requirements
- R1: An input pixel with `in_valid` high appears on the outputs exactly two clock cycles later with `out_valid` high and with its column and row unchanged. Cycles without valid input produce cycles without valid output.
- R2: When bit 8 of `cfg_enable` is 0, every output pixel equals its input pixel, whatever the other bits of `cfg_enable` and the channel words hold.
- R3: Bit 31 of a channel's style word is that channel's visibility. When it is 0, that channel marks no pixel.
- R4: The highlight channel marks a pixel when luma ≥ its style bits 7:0, and it ignores its bits 15:8. The shadow channel marks a pixel when luma ≤ its style bits 15:8, and it ignores its bits 7:0. When both channels mark a pixel, the highlight channel is used.
- R5: With `HDMI_MODE` = 1, a highlight threshold above 0xE8 marks no pixel, and a threshold of exactly 0xE8 still marks pixels.
- R6: The pattern phase is ((col + row) if style bit 24 is 0, else (col − row)) plus the channel offset, taken modulo 8.
- R7: Style bits 21:20 select the pattern. 0 lights dots where (phase mod 4) = 0 and (row mod 4) = 0. 1 lights thin lines at phase 0 and 1. 2 lights thick lines at phase 0 to 3. 3 lights nothing.
- R8: Each channel's offset starts at 0 after reset. On every cycle with `frame_start` high it advances by 1, 2, 4 or 8 (modulo 8) for style bits 29:28 = 0, 1, 2, 3, and it holds at all other times.
- R9: A lit pixel becomes, per component, floor((in·(7−op) + tint·(op+1)) / 8). Here op is style bits 18:16, and the tint is Y = bits 23:16, U = bits 15:8, V = bits 7:0 of the tint word, with bits 31:24 ignored. Pixels that are not lit pass unchanged.
- R10: While `rst_n` is low, the output registers are cleared: `out_valid` is 0 and all output data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_col | input | POS_W | Input pixel column |
| in_row | input | POS_W | Input pixel row |
| in_luma | input | 8 | Input Y |
| in_cb | input | 8 | Input U |
| in_cr | input | 8 | Input V |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| cfg_enable | input | 32 | Global enable word, bit 8 used |
| cfg_over_style | input | 32 | Highlight channel style/threshold word |
| cfg_over_tint | input | 32 | Highlight channel tint word |
| cfg_under_style | input | 32 | Shadow channel style/threshold word |
| cfg_under_tint | input | 32 | Shadow channel tint word |
| out_valid | output | 1 | Output pixel qualifier |
| out_col | output | POS_W | Output pixel column |
| out_row | output | POS_W | Output pixel row |
| out_luma | output | 8 | Output Y |
| out_cb | output | 8 | Output U |
| out_cr | output | 8 | Output V |

## Verification
The bench builds the block with its defaults: `POS_W` = 11 and `HDMI_MODE` = 1. The HDMI setting puts the 0xE8 highlight cap within reach, so thresholds on both sides of the cap are driven against high-luma ramps. An 11-bit position is wide enough for the bench to place 16×4 pixel tiles at small coordinates. There, both col + row and col − row wrap through every phase of the 8-pixel pattern, including negative differences.

Speed is stepped from 0 to 3 over several frames to show how each channel's offset moves the pattern. Overlapping thresholds show that the highlight channel takes priority.

// File: rtl/zebra_pkg.sv
// Shared types and field extraction for the zebra overlay.
// Assumes the 32-bit style and tint word layouts given in the brief.
package zebra_pkg;

    localparam int COMP_W   = 8;   // bits per colour component
    localparam int PH_W     = 3;   // pattern period is 2**PH_W pixels
    localparam int NUM_CH   = 2;
    localparam int CH_OVER  = 0;
    localparam int CH_UNDER = 1;
    localparam int ENABLE_BIT = 8;

    typedef enum logic [1:0] {
        PAT_DOTS  = 2'd0,
        PAT_THIN  = 2'd1,
        PAT_THICK = 2'd2,
        PAT_NONE  = 2'd3
    } pat_style_e;

    typedef struct packed {
        logic              vis;
        logic [1:0]        speed;
        logic              angle;
        pat_style_e        style;
        logic [2:0]        opacity;
        logic [COMP_W-1:0] thr_under;
        logic [COMP_W-1:0] thr_over;
    } chan_cfg_t;

    // Pull the used fields out of a packed style/threshold word.
    function automatic chan_cfg_t unpack_style(input logic [31:0] w);
        chan_cfg_t c;
        c.vis       = w[31];
        c.speed     = w[29:28];
        c.angle     = w[24];
        c.style     = pat_style_e'(w[21:20]);
        c.opacity   = w[18:16];
        c.thr_under = w[15:8];
        c.thr_over  = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/zebra_motion.sv
// Per-channel pattern offset: steps by 2**speed on each frame start.
// Assumes frame_start is a single-cycle pulse; the offset wraps modulo 2**PH_W.
module zebra_motion #(
    parameter int PH_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic [1:0]      speed,
    output logic [PH_W-1:0] offset
);
    logic [PH_W-1:0] step;

    // Step size chosen by the speed field.
    always_comb step = PH_W'(1) << speed;

    // Offset register, cleared by reset and advanced once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           offset <= '0;
        else if (frame_start) offset <= offset + step;
    end
endmodule

// File: rtl/zebra_mark.sv
// Exposure test and pattern lookup for one channel (combinational).
// Assumes PH_W >= 3 so dots (mod 4) and lines (mod 8) are both expressible.
module zebra_mark
    import zebra_pkg::*;
#(
    parameter int          POS_W     = 11,
    parameter int          PHASE_W   = 3,
    parameter bit          IS_OVER   = 1'b1,
    parameter bit          HDMI_MODE = 1'b1,
    parameter logic [7:0]  CAP       = 8'hE8
) (
    input  chan_cfg_t          cfg,
    input  logic [COMP_W-1:0]  luma,
    input  logic [POS_W-1:0]   px,
    input  logic [POS_W-1:0]   py,
    input  logic [PHASE_W-1:0] offset,
    output logic               hit,
    output logic               lit
);
    localparam logic [PHASE_W-1:0] THIN_LIM  = PHASE_W'(1) << (PHASE_W-2);
    localparam logic [PHASE_W-1:0] THICK_LIM = PHASE_W'(1) << (PHASE_W-1);

    logic [PHASE_W-1:0] phase;
    logic               expo;
    logic               patt;

    // Diagonal phase from position, angle and the frame offset.
    always_comb begin
        if (cfg.angle) phase = px[PHASE_W-1:0] - py[PHASE_W-1:0] + offset;
        else           phase = px[PHASE_W-1:0] + py[PHASE_W-1:0] + offset;
    end

    generate
        if (IS_OVER) begin : g_over
            // Highlight test against the low threshold field, with optional cap.
            always_comb expo = (luma >= cfg.thr_over) && !(HDMI_MODE && (cfg.thr_over > CAP));
        end else begin : g_under
            // Shadow test against the high threshold field.
            always_comb expo = (luma <= cfg.thr_under);
        end
    endgenerate

    // Pattern coverage for the selected style.
    always_comb begin
        unique case (cfg.style)
            PAT_DOTS:  patt = (phase[1:0] == 2'd0) && (py[1:0] == 2'd0);
            PAT_THIN:  patt = (phase < THIN_LIM);
            PAT_THICK: patt = (phase < THICK_LIM);
            default:   patt = 1'b0;
        endcase
    end

    // Combine visibility, exposure and pattern.
    always_comb begin
        hit = cfg.vis & expo;
        lit = hit & patt;
    end
endmodule

// File: rtl/zebra_blend.sv
// One-component opacity mix: (base*(7-op) + tint*(op+1)) / 8.
// Assumes 3-bit opacity; op = 7 yields the tint exactly.
module zebra_blend #(
    parameter int W = 8
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] tint,
    input  logic [2:0]   op,
    output logic [W-1:0] mix
);
    logic [W+2:0] sum;

    // Weighted sum with eight parts in total, then drop three bits.
    always_comb begin
        sum = (W+3)'(base) * (W+3)'(3'd7 - op) + (W+3)'(tint) * (W+3)'({1'b0, op} + 4'd1);
        mix = sum[W+2:3];
    end
endmodule

// File: rtl/zebra_overlay.sv
// Top of the zebra overlay: two channels of exposure marking, a priority
// pick, and an opacity blend, in a two-register pipeline.
// Assumes configuration words are held stable while pixels stream.
module zebra_overlay
    import zebra_pkg::*;
#(
    parameter int         POS_W     = 11,
    parameter bit         HDMI_MODE = 1'b1,
    parameter logic [7:0] HDMI_CAP  = 8'hE8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [POS_W-1:0]  in_col,
    input  logic [POS_W-1:0]  in_row,
    input  logic [7:0]        in_luma,
    input  logic [7:0]        in_cb,
    input  logic [7:0]        in_cr,
    input  logic              frame_start,
    input  logic [31:0]       cfg_enable,
    input  logic [31:0]       cfg_over_style,
    input  logic [31:0]       cfg_over_tint,
    input  logic [31:0]       cfg_under_style,
    input  logic [31:0]       cfg_under_tint,
    output logic              out_valid,
    output logic [POS_W-1:0]  out_col,
    output logic [POS_W-1:0]  out_row,
    output logic [7:0]        out_luma,
    output logic [7:0]        out_cb,
    output logic [7:0]        out_cr
);
    localparam int PIX_W = 3 * COMP_W;

    chan_cfg_t        cfg    [NUM_CH];
    logic [PIX_W-1:0] tint   [NUM_CH];
    logic [PH_W-1:0]  ofs_q  [NUM_CH];
    logic [NUM_CH-1:0] hit, lit;

    logic             sel_lit;
    logic [PIX_W-1:0] sel_tint;
    logic [2:0]       sel_op;

    logic             s1_valid, s1_lit;
    logic [POS_W-1:0] s1_col, s1_row;
    logic [PIX_W-1:0] s1_pix, s1_tint, mixed;
    logic [2:0]       s1_op;

    // Decode the channel words into typed fields.
    always_comb begin
        cfg[CH_OVER]   = unpack_style(cfg_over_style);
        cfg[CH_UNDER]  = unpack_style(cfg_under_style);
        tint[CH_OVER]  = cfg_over_tint[PIX_W-1:0];
        tint[CH_UNDER] = cfg_under_tint[PIX_W-1:0];
    end

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            zebra_motion #(.PH_W(PH_W)) u_motion (
                .clk         (clk),
                .rst_n       (rst_n),
                .frame_start (frame_start),
                .speed       (cfg[ch].speed),
                .offset      (ofs_q[ch])
            );
            zebra_mark #(
                .POS_W     (POS_W),
                .PHASE_W   (PH_W),
                .IS_OVER   (ch == CH_OVER),
                .HDMI_MODE (HDMI_MODE),
                .CAP       (HDMI_CAP)
            ) u_mark (
                .cfg    (cfg[ch]),
                .luma   (in_luma),
                .px     (in_col),
                .py     (in_row),
                .offset (ofs_q[ch]),
                .hit    (hit[ch]),
                .lit    (lit[ch])
            );
        end
    endgenerate

    // Priority pick: highlight channel first, then shadow, gated by enable.
    always_comb begin
        sel_lit  = 1'b0;
        sel_tint = tint[CH_OVER];
        sel_op   = cfg[CH_OVER].opacity;
        if (cfg_enable[ENABLE_BIT]) begin
            if (hit[CH_OVER]) begin
                sel_lit = lit[CH_OVER];
            end else if (hit[CH_UNDER]) begin
                sel_lit  = lit[CH_UNDER];
                sel_tint = tint[CH_UNDER];
                sel_op   = cfg[CH_UNDER].opacity;
            end
        end
    end

    // Stage 1: register the pixel together with its overlay decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_lit   <= 1'b0;
            s1_col   <= '0;
            s1_row   <= '0;
            s1_pix   <= '0;
            s1_tint  <= '0;
            s1_op    <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_lit   <= sel_lit;
            s1_col   <= in_col;
            s1_row   <= in_row;
            s1_pix   <= {in_luma, in_cb, in_cr};
            s1_tint  <= sel_tint;
            s1_op    <= sel_op;
        end
    end

    generate
        for (genvar k = 0; k < 3; k++) begin : g_comp
            zebra_blend #(.W(COMP_W)) u_blend (
                .base (s1_pix [k*COMP_W +: COMP_W]),
                .tint (s1_tint[k*COMP_W +: COMP_W]),
                .op   (s1_op),
                .mix  (mixed  [k*COMP_W +: COMP_W])
            );
        end
    endgenerate

    // Stage 2: register the blended or passed-through pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_col   <= '0;
            out_row   <= '0;
            {out_luma, out_cb, out_cr} <= '0;
        end else begin
            out_valid <= s1_valid;
            out_col   <= s1_col;
            out_row   <= s1_row;
            {out_luma, out_cb, out_cr} <= s1_lit ? mixed : s1_pix;
        end
    end
endmodule

// File: rtl/zebra_overlay_chk.sv
// Assertion checker for zebra_overlay, attached with bind.
// Assumes a synchronous active-low reset; the age counter keeps $past inside post-reset time.
module zebra_overlay_chk #(
    parameter int POS_W = 11,
    parameter int PH_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [POS_W-1:0] in_col,
    input logic [POS_W-1:0] in_row,
    input logic [7:0]       in_luma,
    input logic [7:0]       in_cb,
    input logic [7:0]       in_cr,
    input logic             frame_start,
    input logic [31:0]      cfg_enable,
    input logic [31:0]      cfg_over_style,
    input logic [31:0]      cfg_under_style,
    input logic             out_valid,
    input logic [POS_W-1:0] out_col,
    input logic [POS_W-1:0] out_row,
    input logic [7:0]       out_luma,
    input logic [7:0]       out_cb,
    input logic [7:0]       out_cr,
    input logic [PH_W-1:0]  ofs_over,
    input logic [PH_W-1:0]  ofs_under
);
    logic [1:0] age;
    logic       rst_q;

    // Count cycles since reset release, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)           age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    // Immediate check that outputs leave reset cleared (R10).
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
        if (rst_n && !rst_q)
            p_reset_clear_r10: assert (!out_valid && out_luma == 8'd0 && out_cb == 8'd0 && out_cr == 8'd0);
    end

    p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_pos_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && out_valid) |-> (out_col == $past(in_col, 2) && out_row == $past(in_row, 2)));

    p_enable_off_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && $past(in_valid, 2) && !$past(cfg_enable[8], 2)) |->
        (out_luma == $past(in_luma, 2) && out_cb == $past(in_cb, 2) && out_cr == $past(in_cr, 2)));

    p_vis_off_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && $past(in_valid, 2) && !$past(cfg_over_style[31], 2) && !$past(cfg_under_style[31], 2)) |->
        (out_luma == $past(in_luma, 2) && out_cb == $past(in_cb, 2) && out_cr == $past(in_cr, 2)));

    p_offset_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(ofs_over) && $stable(ofs_under)));
endmodule

bind zebra_overlay zebra_overlay_chk #(.POS_W(POS_W), .PH_W(zebra_pkg::PH_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_col          (in_col),
    .in_row          (in_row),
    .in_luma         (in_luma),
    .in_cb           (in_cb),
    .in_cr           (in_cr),
    .frame_start     (frame_start),
    .cfg_enable      (cfg_enable),
    .cfg_over_style  (cfg_over_style),
    .cfg_under_style (cfg_under_style),
    .out_valid       (out_valid),
    .out_col         (out_col),
    .out_row         (out_row),
    .out_luma        (out_luma),
    .out_cb          (out_cb),
    .out_cr          (out_cr),
    .ofs_over        (ofs_q[0]),
    .ofs_under       (ofs_q[1])
);

// File: tb/tb_zebra_overlay.sv
// Scoreboard bench: a driver pushes expected pixels, a monitor pops and compares.
module tb_zebra_overlay;
    localparam int POS_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [POS_W-1:0] in_col = '0, in_row = '0;
    logic [7:0]       in_luma = '0, in_cb = '0, in_cr = '0;
    logic             frame_start = 1'b0;
    logic [31:0]      cfg_enable = '0, cfg_over_style = '0, cfg_over_tint = 32'h0000_8080;
    logic [31:0]      cfg_under_style = '0, cfg_under_tint = 32'h0000_8080;
    logic             out_valid;
    logic [POS_W-1:0] out_col, out_row;
    logic [7:0]       out_luma, out_cb, out_cr;

    zebra_overlay #(.POS_W(POS_W), .HDMI_MODE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_col(in_col), .in_row(in_row),
        .in_luma(in_luma), .in_cb(in_cb), .in_cr(in_cr), .frame_start(frame_start),
        .cfg_enable(cfg_enable), .cfg_over_style(cfg_over_style), .cfg_over_tint(cfg_over_tint),
        .cfg_under_style(cfg_under_style), .cfg_under_tint(cfg_under_tint),
        .out_valid(out_valid), .out_col(out_col), .out_row(out_row),
        .out_luma(out_luma), .out_cb(out_cb), .out_cr(out_cr));

    always #5 clk = ~clk;

    typedef struct {
        int    y, u, v, c, r, due;
        string tag;
    } exp_t;

    exp_t  sbq[$];
    int    cyc = 0;
    int    n_chk = 0, n_bad = 0;
    int    ofs[2] = '{0, 0};
    bit    done = 1'b0;

    always @(posedge clk) cyc++;

    // Reference model written from the requirements.
    function automatic void model(input int c, r, yl, u, v, output int oy, ou, ov);
        logic [31:0] st, tn;
        int sel, ph, op, sty, ot, ut;
        bit ho, hu, lt;
        oy = yl; ou = u; ov = v;
        if (!cfg_enable[8]) return;
        ot = int'(cfg_over_style[7:0]);
        ut = int'(cfg_under_style[15:8]);
        ho = cfg_over_style[31] && yl >= ot && ot <= 232;
        hu = cfg_under_style[31] && yl <= ut;
        if (ho)      begin sel = 0; st = cfg_over_style;  tn = cfg_over_tint;  end
        else if (hu) begin sel = 1; st = cfg_under_style; tn = cfg_under_tint; end
        else return;
        ph  = ((st[24] ? c - r : c + r) + ofs[sel]) & 7;
        sty = int'(st[21:20]);
        case (sty)
            0: lt = ((ph & 3) == 0) && ((r & 3) == 0);
            1: lt = ph < 2;
            2: lt = ph < 4;
            default: lt = 1'b0;
        endcase
        if (!lt) return;
        op = int'(st[18:16]);
        oy = (yl * (7 - op) + int'(tn[23:16]) * (op + 1)) / 8;
        ou = (u  * (7 - op) + int'(tn[15:8])  * (op + 1)) / 8;
        ov = (v  * (7 - op) + int'(tn[7:0])   * (op + 1)) / 8;
    endfunction

    task automatic push_pix(input int c, r, yl, u, v, input string tag);
        exp_t e;
        @(posedge clk); #1;
        in_valid = 1'b1; in_col = POS_W'(c); in_row = POS_W'(r);
        in_luma = 8'(yl); in_cb = 8'(u); in_cr = 8'(v);
        model(c, r, yl, u, v, e.y, e.u, e.v);
        e.c = c; e.r = r; e.due = cyc + 2; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; in_valid = 1'b0;
        end
    endtask

    task automatic new_frame();
        @(posedge clk); #1;
        in_valid = 1'b0; frame_start = 1'b1;
        ofs[0] = (ofs[0] + (1 << cfg_over_style[29:28])) & 7;
        ofs[1] = (ofs[1] + (1 << cfg_under_style[29:28])) & 7;
        @(posedge clk); #1; frame_start = 1'b0;
    endtask

    // A 16x4 tile with a luma ramp; chroma varies by column.
    task automatic sweep(input int y0, input int ystep, input string tag);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 16; c++)
                push_pix(c, r, (y0 + (r * 16 + c) * ystep) & 255, (c * 9) & 255, 255 - c * 7, tag);
        idle(1);
    endtask

    // Monitor: compare each valid output with the next expected entry.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (sbq.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R1 unexpected output pixel at cycle %0d (actual valid=1, expected none)", cyc);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                n_chk++;
                if (e.due != cyc || int'(out_col) != e.c || int'(out_row) != e.r) begin
                    n_bad++;
                    $display("FAIL R1 (%s) timing/position: actual cyc=%0d col=%0d row=%0d, expected cyc=%0d col=%0d row=%0d",
                             e.tag, cyc, out_col, out_row, e.due, e.c, e.r);
                end else if (int'(out_luma) != e.y || int'(out_cb) != e.u || int'(out_cr) != e.v) begin
                    n_bad++;
                    $display("FAIL %s pixel (%0d,%0d): actual %0d/%0d/%0d, expected %0d/%0d/%0d",
                             e.tag, e.c, e.r, out_luma, out_cb, out_cr, e.y, e.u, e.v);
                end
            end
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1; n_chk++; n_bad++;
            $display("FAIL watchdog expired (actual running, expected finished)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: outputs cleared while reset is held.
        n_chk++;
        if (out_valid !== 1'b0 || out_luma !== 8'd0 || out_cb !== 8'd0 || out_cr !== 8'd0) begin
            n_bad++;
            $display("FAIL R10 reset outputs: actual v=%b %0d/%0d/%0d, expected v=0 0/0/0",
                     out_valid, out_luma, out_cb, out_cr);
        end
        @(posedge clk); #1; rst_n = 1'b1;

        // R2: global enable clear, every other bit set.
        cfg_enable     = 32'hFFFF_FEFF;
        cfg_over_style = 32'h8027_0000;   // visible, thick, op 7, threshold 0
        cfg_over_tint  = 32'h0010_2030;
        sweep(0, 4, "R2");

        // R4, R9: highlight channel, opaque, under-field of this word set to 0xFF.
        cfg_enable     = 32'h0000_0100;
        cfg_over_style = 32'h8027_FFC0;
        sweep(0, 4, "R4");

        // R9: mid opacity, tint top byte is junk and must be ignored.
        cfg_over_style = 32'h8023_00A0;
        cfg_over_tint  = 32'hAB40_A020;
        sweep(128, 2, "R9");

        // R4, R6: shadow channel, thin lines at -45 degrees, over-field 0.
        cfg_over_style  = 32'h0027_0000;
        cfg_under_style = 32'h8115_5000;
        cfg_under_tint  = 32'h00F0_1080;
        sweep(0, 2, "R4");
        sweep(0, 2, "R6");

        // R4: both channels mark the same pixels; highlight must win.
        cfg_over_style  = 32'h8027_0020;
        cfg_under_style = 32'h8027_6000;
        cfg_over_tint   = 32'h00EB_8080;
        sweep(0, 2, "R4");

        // R3: both channels hidden although thresholds would mark all.
        cfg_over_style  = 32'h0027_0000;
        cfg_under_style = 32'h0027_FF00;
        sweep(0, 4, "R3");

        // R5: cap above 0xE8 blocks highlights, 0xE8 itself still marks.
        cfg_under_style = 32'h0000_0000;
        cfg_over_style  = 32'h8027_00F0;
        sweep(200, 1, "R5");
        cfg_over_style  = 32'h8027_00E8;
        sweep(200, 1, "R5");

        // R7: dots, then the reserved style code.
        cfg_over_style = 32'h8007_0000;
        sweep(0, 1, "R7");
        cfg_over_style = 32'h8137_0000;
        sweep(0, 1, "R7");

        // R8, R6: each speed across three frames, both angles.
        for (int s = 0; s < 4; s++) begin
            cfg_over_style  = 32'h8017_0080 | (32'(s) << 28);
            cfg_under_style = 32'h8127_7F00 | (32'((s + 1) & 3) << 28);
            for (int f = 0; f < 3; f++) begin
                new_frame();
                sweep(0, 4, "R8");
            end
        end

        idle(4);
        // R1: nothing left unmatched in the scoreboard.
        n_chk++;
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL R1 pixels never emitted: actual %0d pending, expected 0", sbq.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule